// File: doc/BRIEF.md
# Cycle, Instret and Timer Counter Unit

This block keeps the three free-running 64-bit counters of a small RISC-V core: a clock-cycle count, a retired-instruction count and a real-time count. It also holds the timer compare register that drives the machine timer interrupt. The core reaches all of it through a simple CSR port made of an address, write data, a write strobe and a combinational read-data return. Each 64-bit value is seen as two 32-bit halves at separate addresses.

A counter-inhibit register lets software pause the cycle counter and the retired-instruction counter separately. The real-time counter cannot be paused. It advances once every `TIME_DIV` clocks from an internal prescaler. The interrupt output is high while the real-time count is at or above the compare value. The compare register comes out of reset at all ones, so the interrupt stays quiet until software programs it.

Top module: `perf_counter_unit`

## Requirements
- R1: On a synchronous high level of `rst_i`, the cycle, instret and time counters and the prescaler clear to zero, the inhibit register clears to zero, the compare register loads all ones, and `timer_irq_o` is low.
- R2: The cycle counter adds one at every clock edge while inhibit bit 0 is clear, and carries from the low half into the high half. Its low half reads at 0xC00 and its high half at 0xC80.
- R3: The instret counter adds one at each clock edge where `retire_i` is high, while inhibit bit 2 is clear. Its low half reads at 0xC02 and its high half at 0xC82.
- R4: The time counter adds one every `TIME_DIV` clocks, with the first step at the `TIME_DIV`-th edge after reset. Inhibit bits never stop it. Its low half reads at 0xC01 and its high half at 0xC81, and CSR writes to those two addresses leave it unchanged.
- R5: The inhibit register is at 0xC20-free address 0x320. A write there stores only bits 0 and 2 of the write data. Every other bit reads as zero.
- R6: Writes to 0xB00 or 0xB80 replace the low or high half of the cycle counter, and writes to 0xB02 or 0xB82 do the same for instret. The other half is kept. The new value is visible in the cycle after the write edge. In that edge the write takes the place of any increment.
- R7: The 64-bit compare register is read and written at 0x321 for its low half and 0x322 for its high half.
- R8: `timer_irq_o` is high exactly when the time count is greater than or equal to the compare value. It follows register changes in the same cycle they become visible.
- R9: Reads of any address not named above return zero, and writes to such addresses change no state.
- R10: `csr_rdata_o` is combinational: it shows the register selected by `csr_addr_i` in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One pulse per retired instruction |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_we_i | input | 1 | CSR write strobe |
| csr_rdata_o | output | XLEN | CSR read data for `csr_addr_i` |
| timer_irq_o | output | 1 | Timer interrupt (time >= compare) |

## Verification
Reads are due in the same cycle as the address, because the read mux is combinational. A write or a retire pulse applied in one cycle shows up after exactly one clock edge, and the interrupt follows any register change in that same later cycle. The bench drives its inputs on the falling edge and advances a behavioural model on the rising edge using those inputs. On the next falling edge, before it drives new inputs, it compares the read data and the interrupt against the model. In this way every result is checked in the first cycle it is due, and this happens on every clock, including the prescaler boundaries and the carry from the low half to the high half.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
   localparam logic [11:0] CSR_INHIBIT   = 12'h320;
   localparam logic [11:0] CSR_CMP_LO    = 12'h321;
   localparam logic [11:0] CSR_CMP_HI    = 12'h322;
   localparam logic [11:0] RD_TIME_LO    = 12'hC01;
   localparam logic [11:0] RD_TIME_HI    = 12'hC81;

   localparam int NUM_EVT     = 2;
   localparam int EVT_CYCLE   = 0;
   localparam int EVT_INSTRET = 1;

   function automatic logic [11:0] evt_rd_lo(input int idx);
      return (idx == EVT_CYCLE) ? 12'hC00 : 12'hC02;
   endfunction

   function automatic logic [11:0] evt_rd_hi(input int idx);
      return (idx == EVT_CYCLE) ? 12'hC80 : 12'hC82;
   endfunction

   function automatic logic [11:0] evt_wr_lo(input int idx);
      return (idx == EVT_CYCLE) ? 12'hB00 : 12'hB02;
   endfunction

   function automatic logic [11:0] evt_wr_hi(input int idx);
      return (idx == EVT_CYCLE) ? 12'hB80 : 12'hB82;
   endfunction

   function automatic int evt_inh_bit(input int idx);
      return (idx == EVT_CYCLE) ? 0 : 2;
   endfunction
endpackage

// File: rtl/pc_wide_counter.sv
module pc_wide_counter #(
   parameter int W    = 64,
   parameter int HALF = 32
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            inc_i,
   input  logic            wr_lo_i,
   input  logic            wr_hi_i,
   input  logic [HALF-1:0] wdata_i,
   output logic [W-1:0]    value_o
);
   generate
      if (W != 2 * HALF) begin : g_bad_width
         $error("pc_wide_counter: W must be twice HALF");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)         cnt_q <= '0;
      else if (wr_lo_i)  cnt_q <= {cnt_q[W-1:HALF], wdata_i};
      else if (wr_hi_i)  cnt_q <= {wdata_i, cnt_q[HALF-1:0]};
      else if (inc_i)    cnt_q <= cnt_q + W'(1);
   end

   assign value_o = cnt_q;

   // R2 / R3: no enable and no write means the count holds
   assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable(value_o));

   // R2 / R3: an enabled step adds exactly one
   assert_single_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (inc_i && !wr_lo_i && !wr_hi_i) |=> (value_o == $past(value_o) + W'(1)));

   // R6: a low-half write keeps the high half
   assert_write_keeps_half_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_lo_i |=> (value_o[W-1:HALF] == $past(value_o[W-1:HALF])));
endmodule

// File: rtl/pc_timer.sv
module pc_timer #(
   parameter int W    = 64,
   parameter int HALF = 32,
   parameter int DIV  = 4
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            cmp_wr_lo_i,
   input  logic            cmp_wr_hi_i,
   input  logic [HALF-1:0] wdata_i,
   output logic [W-1:0]    time_o,
   output logic [W-1:0]    cmp_o,
   output logic            irq_o
);
   logic tick;
   logic [W-1:0] time_q;
   logic [W-1:0] cmp_q;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("pc_timer: DIV must be at least 1");
      end
      if (W != 2 * HALF) begin : g_bad_width
         $error("pc_timer: W must be twice HALF");
      end
      if (DIV == 1) begin : g_no_presc
         assign tick = 1'b1;
      end else begin : g_presc
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] presc_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)                presc_q <= '0;
            else if (presc_q == LAST) presc_q <= '0;
            else                      presc_q <= presc_q + PW'(1);
         end
         assign tick = (presc_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)     time_q <= '0;
      else if (tick) time_q <= time_q + W'(1);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)            cmp_q <= '1;
      else if (cmp_wr_lo_i) cmp_q <= {cmp_q[W-1:HALF], wdata_i};
      else if (cmp_wr_hi_i) cmp_q <= {wdata_i, cmp_q[HALF-1:0]};
   end

   assign time_o = time_q;
   assign cmp_o  = cmp_q;
   assign irq_o  = (time_q >= cmp_q);

   // R4: time never moves backwards short of wrap
   assert_time_monotonic_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !(&time_q) |=> (time_q >= $past(time_q)));

   // R7: the compare value only changes on a write
   assert_cmp_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cmp_wr_lo_i && !cmp_wr_hi_i) |=> $stable(cmp_o));

   // R8: once raised, the interrupt stays up until compare is rewritten
   assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (irq_o && !cmp_wr_lo_i && !cmp_wr_hi_i && !(&time_q)) |=> irq_o);
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
   import perfcnt_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int CNT_W    = 64,
   parameter int TIME_DIV = 4
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            retire_i,
   input  logic [11:0]     csr_addr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   input  logic            csr_we_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic            timer_irq_o
);
   localparam int HALF = CNT_W / 2;

   generate
      if (CNT_W != 2 * XLEN) begin : g_bad_cfg
         $error("perf_counter_unit: CNT_W must be twice XLEN");
      end
      if (XLEN < 3) begin : g_bad_xlen
         $error("perf_counter_unit: XLEN too small for inhibit bits");
      end
   endgenerate

   logic [NUM_EVT-1:0] inh_q;
   logic [CNT_W-1:0]   evt_val [NUM_EVT];
   logic [CNT_W-1:0]   time_val;
   logic [CNT_W-1:0]   cmp_val;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         inh_q <= '0;
      end else if (csr_we_i && csr_addr_i == CSR_INHIBIT) begin
         for (int i = 0; i < NUM_EVT; i++) begin
            inh_q[i] <= csr_wdata_i[evt_inh_bit(i)];
         end
      end
   end

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      logic src;
      logic inc;
      logic wr_lo;
      logic wr_hi;
      if (g == EVT_CYCLE) begin : g_src_clk
         assign src = 1'b1;
      end else begin : g_src_ret
         assign src = retire_i;
      end
      assign inc   = src & ~inh_q[g];
      assign wr_lo = csr_we_i && (csr_addr_i == evt_wr_lo(g));
      assign wr_hi = csr_we_i && (csr_addr_i == evt_wr_hi(g));

      pc_wide_counter #(.W(CNT_W), .HALF(HALF)) u_cnt (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .inc_i   (inc),
         .wr_lo_i (wr_lo),
         .wr_hi_i (wr_hi),
         .wdata_i (csr_wdata_i),
         .value_o (evt_val[g])
      );

      // R2 / R3: an inhibited counter with no write stays frozen
      assert_inhibit_freezes_R3: assert property (@(posedge clk_i) disable iff (rst_i)
         (inh_q[g] && !wr_lo && !wr_hi) |=> $stable(evt_val[g]));
   end

   pc_timer #(.W(CNT_W), .HALF(HALF), .DIV(TIME_DIV)) u_timer (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .cmp_wr_lo_i (csr_we_i && csr_addr_i == CSR_CMP_LO),
      .cmp_wr_hi_i (csr_we_i && csr_addr_i == CSR_CMP_HI),
      .wdata_i     (csr_wdata_i),
      .time_o      (time_val),
      .cmp_o       (cmp_val),
      .irq_o       (timer_irq_o)
   );

   always_comb begin
      csr_rdata_o = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (csr_addr_i == evt_rd_lo(i)) csr_rdata_o = evt_val[i][HALF-1:0];
         if (csr_addr_i == evt_rd_hi(i)) csr_rdata_o = evt_val[i][CNT_W-1:HALF];
      end
      case (csr_addr_i)
         RD_TIME_LO: csr_rdata_o = time_val[HALF-1:0];
         RD_TIME_HI: csr_rdata_o = time_val[CNT_W-1:HALF];
         CSR_CMP_LO: csr_rdata_o = cmp_val[HALF-1:0];
         CSR_CMP_HI: csr_rdata_o = cmp_val[CNT_W-1:HALF];
         CSR_INHIBIT: begin
            for (int i = 0; i < NUM_EVT; i++) begin
               csr_rdata_o[evt_inh_bit(i)] = inh_q[i];
            end
         end
         default: ;
      endcase
   end

   // R5: only bits 0 and 2 of the inhibit register can read as one
   assert_inhibit_mask_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (csr_addr_i == CSR_INHIBIT) |-> (csr_rdata_o[XLEN-1:3] == '0 && !csr_rdata_o[1]));
endmodule

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        retire = 1'b0;
   logic [11:0] addr = 12'h000;
   logic [31:0] wdata = 32'h0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   logic [63:0] m_cyc, m_ins, m_tim, m_cmp;
   logic [1:0]  m_inh;
   int          m_presc;

   always #5 clk = ~clk;

   perf_counter_unit u0 (
      .clk_i       (clk),
      .rst_i       (rst),
      .retire_i    (retire),
      .csr_addr_i  (addr),
      .csr_wdata_i (wdata),
      .csr_we_i    (we),
      .csr_rdata_o (rdata),
      .timer_irq_o (irq)
   );

   // behavioural reference, advanced with the inputs seen at the edge
   always @(posedge clk) begin
      if (rst) begin
         m_cyc <= 0; m_ins <= 0; m_tim <= 0; m_presc <= 0;
         m_inh <= 0; m_cmp <= '1;
      end else begin
         if (we && addr == 12'hB00)      m_cyc <= {m_cyc[63:32], wdata};
         else if (we && addr == 12'hB80) m_cyc <= {wdata, m_cyc[31:0]};
         else if (!m_inh[0])             m_cyc <= m_cyc + 1;
         if (we && addr == 12'hB02)      m_ins <= {m_ins[63:32], wdata};
         else if (we && addr == 12'hB82) m_ins <= {wdata, m_ins[31:0]};
         else if (retire && !m_inh[1])   m_ins <= m_ins + 1;
         if (m_presc == DIV - 1) begin
            m_presc <= 0;
            m_tim   <= m_tim + 1;
         end else begin
            m_presc <= m_presc + 1;
         end
         if (we && addr == 12'h320) m_inh <= {wdata[2], wdata[0]};
         if (we && addr == 12'h321) m_cmp <= {m_cmp[63:32], wdata};
         if (we && addr == 12'h322) m_cmp <= {wdata, m_cmp[31:0]};
      end
   end

   function automatic logic [31:0] model_read(input logic [11:0] a);
      case (a)
         12'hC00: return m_cyc[31:0];
         12'hC80: return m_cyc[63:32];
         12'hC02: return m_ins[31:0];
         12'hC82: return m_ins[63:32];
         12'hC01: return m_tim[31:0];
         12'hC81: return m_tim[63:32];
         12'h321: return m_cmp[31:0];
         12'h322: return m_cmp[63:32];
         12'h320: return {29'h0, m_inh[1], 1'b0, m_inh[0]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare_now();
      logic [31:0] exp_rd;
      logic        exp_irq;
      exp_rd  = model_read(addr);
      exp_irq = (m_tim >= m_cmp);
      checks++;
      if (rdata !== exp_rd) begin
         failures++;
         $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, addr, rdata, exp_rd);
      end
      checks++;
      if (irq !== exp_irq) begin
         failures++;
         $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, exp_irq);
      end
   endtask

   task automatic step(input logic [11:0] a, input logic [31:0] d, input logic w, input logic r);
      @(negedge clk);
      compare_now();
      addr = a; wdata = d; we = w; retire = r;
   endtask

   task automatic rd(input logic [11:0] a, input int n);
      for (int i = 0; i < n; i++) step(a, 32'h0, 1'b0, 1'b0);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      step(12'hC00, 0, 0, 0);
      step(12'h321, 0, 0, 0);
      step(12'h322, 0, 0, 0);
      step(12'h320, 0, 0, 1);
      step(12'hC01, 0, 0, 0);
      @(negedge clk); rst = 1'b0;

      // R2: cycle counter free-running
      cur_req = "R2";
      rd(12'hC00, 6);
      rd(12'hC80, 2);

      // R3: instret follows retire pulses
      cur_req = "R3";
      for (int i = 0; i < 12; i++) step(12'hC02, 0, 0, (i % 3) != 1);
      rd(12'hC82, 2);

      // R4: time prescaled, writes to it ignored
      cur_req = "R4";
      rd(12'hC01, 11);
      step(12'hC01, 32'hDEAD_BEEF, 1, 0);
      step(12'hC81, 32'h1234_5678, 1, 0);
      rd(12'hC01, 3);
      rd(12'hC81, 1);

      // R5: inhibit register stores only bits 0 and 2
      cur_req = "R5";
      step(12'h320, 32'hFFFF_FFFF, 1, 0);
      rd(12'h320, 1);
      for (int i = 0; i < 6; i++) step(12'hC00, 0, 0, 1);
      for (int i = 0; i < 4; i++) step(12'hC02, 0, 0, 1);
      rd(12'hC01, 5);
      step(12'h320, 32'h0000_0004, 1, 0);
      rd(12'h320, 1);
      for (int i = 0; i < 4; i++) step(12'hC00, 0, 0, 1);
      for (int i = 0; i < 4; i++) step(12'hC02, 0, 0, 1);
      step(12'h320, 32'hFFFF_FFFA, 1, 0);
      rd(12'h320, 1);
      rd(12'hC00, 3);
      step(12'h320, 32'h0, 1, 0);

      // R6: half writes, carry, write beats increment
      cur_req = "R6";
      step(12'hB80, 32'h0000_0001, 1, 0);
      step(12'hB00, 32'hFFFF_FFFD, 1, 0);
      rd(12'hC00, 4);
      rd(12'hC80, 2);
      step(12'hB02, 32'h0000_0100, 1, 1);
      rd(12'hC02, 2);
      step(12'hB82, 32'hAAAA_0000, 1, 1);
      rd(12'hC82, 1);
      rd(12'hC02, 1);

      // R7: compare register read/write
      cur_req = "R7";
      step(12'h321, 32'h1357_9BDF, 1, 0);
      rd(12'h321, 1);
      step(12'h322, 32'h2468_ACE0, 1, 0);
      rd(12'h322, 1);

      // R8: interrupt rises when time reaches compare
      cur_req = "R8";
      step(12'h322, m_tim[63:32], 1, 0);
      step(12'h321, m_tim[31:0] + 32'd20, 1, 0);
      rd(12'hC01, 100);
      step(12'h321, 32'hFFFF_FFFF, 1, 0);
      step(12'h322, 32'hFFFF_FFFF, 1, 0);
      rd(12'hC01, 4);
      step(12'h321, 32'h0, 1, 0);
      step(12'h322, 32'h0, 1, 0);
      rd(12'h322, 3);

      // R9: unknown addresses
      cur_req = "R9";
      step(12'h7C0, 32'hFFFF_FFFF, 1, 1);
      step(12'hC03, 32'hFFFF_FFFF, 1, 1);
      step(12'h300, 32'hFFFF_FFFF, 1, 0);
      rd(12'h7C0, 1);
      rd(12'hC03, 1);
      rd(12'h000, 1);
      rd(12'h320, 1);
      rd(12'h321, 1);

      // R10: read data follows the address in the same cycle
      cur_req = "R10";
      for (int i = 0; i < 16; i++) begin
         case (i % 4)
            0: step(12'hC00, 0, 0, 1);
            1: step(12'hC01, 0, 0, 0);
            2: step(12'hC02, 0, 0, 1);
            default: step(12'h321, 0, 0, 0);
         endcase
      end
      @(negedge clk);
      compare_now();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule